// File: doc/BRIEF.md
# Self-Reseeding Chaotic Random Word Generator

This block produces a stream of 32-bit pseudo-random words by iterating the logistic map x' = 4·x·(1−x) on an unsigned fixed-point state that has only 32 fractional bits. The product is truncated to 32 bits, so on its own the orbit would decay into short cycles. To counter this, the block perturbs itself at regular intervals. Each time a programmable number of iterations has passed, it overwrites the low byte of the state with a constant noise pattern and feeds that modified word into the map. The perturbation comes only from the block's own state. No outside entropy is used after the seed is loaded, and the output is the raw state with no whitening stage.

Software loads a seed, raises the run enable, and collects one word per clock while the valid strobe is high. The reseed interval can be rewritten while the block is running, which is the means of tuning the balance of ones and zeros in the output. The block also detects a state that has collapsed to zero or to all-ones and reseeds at once.

Top module: `chaos_prng`

## Requirements
- R1: After synchronous reset the state and output equal 32'h1000_0000, the valid strobe is low and the reseed interval is 700.
- R2: Each clock with run enable high and no seed load is one iteration. The new output is bits [61:30] of x·(2^32−x), where x is the (possibly injected) input word, saturated to 32'hFFFF_FFFF when that value reaches 2^32. The valid strobe is high in the cycle after each iteration and low otherwise.
- R3: With run enable low and no seed load, the output holds its value and valid stays low.
- R4: A seed load sets the state to the seed value and clears the iteration counter. A zero seed is replaced by 32'h1000_0000. A load wins over run enable, and no valid is produced for that cycle.
- R5: An interval write stores the written value clamped into the range 600 to 800. The new value governs every following iteration.
- R6: A reseed takes place on the iteration for which the counter has reached the interval minus one, so there are interval-many iterations from one reseed (or load) to the next. On a reseed, bits [7:0] of the map input are replaced by 8'hA5, bits [31:8] are kept, and the counter returns to zero. Otherwise the counter increments.
- R7: If the state is 0 or 32'hFFFF_FFFF, the next iteration is a reseed and clears the counter, whatever the counter value.
- R8: If an interval write lowers the interval to or below the current counter value plus one, the very next iteration is a reseed.
- R9: The output word is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_ld | input | 1 | Load seed_val into the state and clear the counter |
| seed_val | input | 32 | Seed word |
| run_en | input | 1 | Perform one iteration per clock |
| intv_wr | input | 1 | Write the reseed interval |
| intv_val | input | 16 | Requested interval, clamped to 600..800 |
| rnd_out | output | 32 | Current state, the random word |
| rnd_vld | output | 1 | High one cycle per new word |

## Verification
On every cycle, the assertions check the strobe and hold behaviour and the effect of a seed load, including substitution of a zero seed. They also check that the stored interval stays inside its clamp range, that the counter clears after a due reseed or a trapped state, and that the output never becomes zero. The exact map arithmetic, the value of the injected byte, and the iteration on which a reseed falls under each interval setting cannot be shown by those properties. They appear only in the bench's scenarios. These scenarios run seeded sequences several thousand steps long against an independently computed orbit, with in-range, too-small, too-large and abruptly lowered intervals.

// File: rtl/chaos_pkg.sv
package chaos_pkg;

    typedef enum logic [1:0] {
        SK_HOLD   = 2'd0,
        SK_MAP    = 2'd1,
        SK_RESEED = 2'd2,
        SK_LOAD   = 2'd3
    } step_kind_t;

    typedef struct packed {
        logic load;
        logic iterate;
        logic reseed;
    } step_ctl_t;

    function automatic step_kind_t classify(input step_ctl_t c);
        if (c.load)
            return SK_LOAD;
        else if (c.iterate && c.reseed)
            return SK_RESEED;
        else if (c.iterate)
            return SK_MAP;
        else
            return SK_HOLD;
    endfunction

    function automatic int unsigned clamp_range(input int unsigned v,
                                                input int unsigned lo,
                                                input int unsigned hi);
        if (v < lo)
            return lo;
        else if (v > hi)
            return hi;
        else
            return v;
    endfunction

endpackage

// File: rtl/chaos_map_core.sv
module chaos_map_core #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_in,
    output logic [W-1:0] y_out
);
    localparam int PW = 2 * W + 1;
    localparam int SW = W + 3;

    logic [W:0]    one_minus;
    logic [PW-1:0] prod;
    logic [SW-1:0] scaled;

    always_comb begin
        one_minus = {1'b1, {W{1'b0}}} - {1'b0, x_in};
        prod      = {{(W + 1){1'b0}}, x_in} * {{W{1'b0}}, one_minus};
        scaled    = prod[PW-1:W-2];
        if (|scaled[SW-1:W])
            y_out = '1;
        else
            y_out = scaled[W-1:0];
    end
endmodule

// File: rtl/chaos_inject.sv
module chaos_inject #(
    parameter int             W         = 32,
    parameter int             NOISE_W   = 8,
    parameter logic [NOISE_W-1:0] NOISE_PAT = 8'hA5
) (
    input  logic [W-1:0] x_in,
    input  logic         reseed,
    output logic [W-1:0] src_out
);
    logic [W-1:0] forced;

    generate
        if (NOISE_W >= W) begin : g_full
            assign forced = NOISE_PAT[W-1:0];
        end else begin : g_low
            assign forced = {x_in[W-1:NOISE_W], NOISE_PAT};
        end
    endgenerate

    assign src_out = reseed ? forced : x_in;
endmodule

// File: rtl/chaos_reseed_ctl.sv
module chaos_reseed_ctl #(
    parameter int INTV_W   = 16,
    parameter int INTV_MIN = 600,
    parameter int INTV_MAX = 800,
    parameter int INTV_DEF = 700,
    localparam int CNT_W   = $clog2(INTV_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              iterate,
    input  logic              trapped,
    input  logic              intv_wr,
    input  logic [INTV_W-1:0] intv_val,
    output logic              reseed,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  intv_q
);
    import chaos_pkg::*;

    logic [CNT_W-1:0] intv_next;
    logic             due;

    always_comb begin
        intv_next = CNT_W'(clamp_range(int'(intv_val), INTV_MIN, INTV_MAX));
        due       = (cnt_q >= (intv_q - CNT_W'(1)));
        reseed    = trapped || due;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            intv_q <= CNT_W'(INTV_DEF);
        end else if (intv_wr) begin
            intv_q <= intv_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= '0;
        end else if (iterate) begin
            if (reseed)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/chaos_prng.sv
module chaos_prng #(
    parameter int                 STATE_W   = 32,
    parameter int                 NOISE_W   = 8,
    parameter logic [NOISE_W-1:0] NOISE_PAT = 8'hA5,
    parameter int                 INTV_W    = 16,
    parameter int                 INTV_MIN  = 600,
    parameter int                 INTV_MAX  = 800,
    parameter int                 INTV_DEF  = 700,
    parameter logic [STATE_W-1:0] DEF_SEED  = 32'h1000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               seed_ld,
    input  logic [STATE_W-1:0] seed_val,
    input  logic               run_en,
    input  logic               intv_wr,
    input  logic [INTV_W-1:0]  intv_val,
    output logic [STATE_W-1:0] rnd_out,
    output logic               rnd_vld
);
    import chaos_pkg::*;

    localparam int CNT_W = $clog2(INTV_MAX + 1);

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] map_src;
    logic [STATE_W-1:0] map_res;
    logic [STATE_W-1:0] seed_nz;
    logic               trapped;
    logic               reseed;
    logic [CNT_W-1:0]   cnt_w;
    logic [CNT_W-1:0]   intv_w;
    logic               vld_q;
    step_ctl_t          ctl;
    step_kind_t         kind;

    always_comb begin
        trapped     = (state_q == '0) || (&state_q);
        ctl.load    = seed_ld;
        ctl.iterate = run_en && !seed_ld;
        ctl.reseed  = reseed;
        kind        = classify(ctl);
        seed_nz     = (seed_val == '0) ? DEF_SEED : seed_val;
    end

    chaos_reseed_ctl #(
        .INTV_W   (INTV_W),
        .INTV_MIN (INTV_MIN),
        .INTV_MAX (INTV_MAX),
        .INTV_DEF (INTV_DEF)
    ) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .iterate  (ctl.iterate),
        .trapped  (trapped),
        .intv_wr  (intv_wr),
        .intv_val (intv_val),
        .reseed   (reseed),
        .cnt_q    (cnt_w),
        .intv_q   (intv_w)
    );

    chaos_inject #(
        .W         (STATE_W),
        .NOISE_W   (NOISE_W),
        .NOISE_PAT (NOISE_PAT)
    ) u_inj (
        .x_in    (state_q),
        .reseed  (reseed),
        .src_out (map_src)
    );

    chaos_map_core #(
        .W (STATE_W)
    ) u_map (
        .x_in  (map_src),
        .y_out (map_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DEF_SEED;
            vld_q   <= 1'b0;
        end else begin
            unique case (kind)
                SK_LOAD:            state_q <= seed_nz;
                SK_MAP, SK_RESEED:  state_q <= map_res;
                default:            state_q <= state_q;
            endcase
            vld_q <= (kind == SK_MAP) || (kind == SK_RESEED);
        end
    end

    assign rnd_out = state_q;
    assign rnd_vld = vld_q;
endmodule

// File: rtl/chaos_prng_chk.sv
module chaos_prng_chk #(
    parameter int                 STATE_W  = 32,
    parameter int                 INTV_MIN = 600,
    parameter int                 INTV_MAX = 800,
    parameter logic [STATE_W-1:0] DEF_SEED = 32'h1000_0000,
    localparam int                CNT_W    = $clog2(INTV_MAX + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               seed_ld,
    input logic [STATE_W-1:0] seed_val,
    input logic               run_en,
    input logic [STATE_W-1:0] rnd_out,
    input logic               rnd_vld,
    input logic [CNT_W-1:0]   cnt_w,
    input logic [CNT_W-1:0]   intv_w
);
    logic out_trapped;
    assign out_trapped = (rnd_out == '0) || (&rnd_out);

    // R2: each iteration yields a strobe in the next cycle
    p_vld_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run_en && !seed_ld) |=> rnd_vld);

    // R3: idle cycles hold the word and keep valid low
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !seed_ld) |=> (!rnd_vld && $stable(rnd_out)));

    // R4: a load places the (non-zero) seed and gives no strobe
    p_seed_load_r4: assert property (@(posedge clk) disable iff (rst)
        seed_ld |=> (!rnd_vld && (rnd_out ==
            (($past(seed_val) == '0) ? DEF_SEED : $past(seed_val)))));

    // R4: a load clears the counter
    p_load_cnt_r4: assert property (@(posedge clk) disable iff (rst)
        seed_ld |=> (cnt_w == '0));

    // R5: stored interval always inside the clamp range
    p_intv_range_r5: assert property (@(posedge clk) disable iff (rst)
        (intv_w >= CNT_W'(INTV_MIN)) && (intv_w <= CNT_W'(INTV_MAX)));

    // R6: a due reseed returns the counter to zero
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (run_en && !seed_ld && (cnt_w >= intv_w - CNT_W'(1))) |=> (cnt_w == '0));

    // R7: a trapped state is left through a reseed that clears the counter
    p_trap_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (run_en && !seed_ld && out_trapped) |=> (cnt_w == '0));

    // R9: the word is never zero
    p_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        rnd_out != '0);
endmodule

bind chaos_prng chaos_prng_chk #(
    .STATE_W  (STATE_W),
    .INTV_MIN (INTV_MIN),
    .INTV_MAX (INTV_MAX),
    .DEF_SEED (DEF_SEED)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .seed_ld  (seed_ld),
    .seed_val (seed_val),
    .run_en   (run_en),
    .rnd_out  (rnd_out),
    .rnd_vld  (rnd_vld),
    .cnt_w    (cnt_w),
    .intv_w   (intv_w)
);

// File: tb/sim_chaos_prng.sv
module sim_chaos_prng;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_ld = 1'b0;
    logic [31:0] seed_val = '0;
    logic        run_en = 1'b0;
    logic        intv_wr = 1'b0;
    logic [15:0] intv_val = '0;
    logic [31:0] rnd_out;
    logic        rnd_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference orbit
    logic [31:0] m_state;
    int          m_cnt;
    int          m_intv;

    always #5 clk = ~clk;

    chaos_prng u0 (
        .clk      (clk),
        .rst      (rst),
        .seed_ld  (seed_ld),
        .seed_val (seed_val),
        .run_en   (run_en),
        .intv_wr  (intv_wr),
        .intv_val (intv_val),
        .rnd_out  (rnd_out),
        .rnd_vld  (rnd_vld)
    );

    // {seed, expected word after one iteration}
    localparam logic [63:0] VEC [7] = '{
        {32'h1000_0000, 32'h3C00_0000},   // R2 1/16 -> 0.234375
        {32'h2000_0000, 32'h7000_0000},   // R2 1/8  -> 0.4375
        {32'h4000_0000, 32'hC000_0000},   // R2 1/4  -> 3/4
        {32'h3C00_0000, 32'hB7C0_0000},   // R2
        {32'h8000_0000, 32'hFFFF_FFFF},   // R2 saturation at 1/2
        {32'hFFFF_FFFF, 32'h0000_016B},   // R7 trapped seed, injected step
        {32'h0000_0000, 32'h3C00_0000}    // R4 zero seed replaced
    };

    function automatic logic [31:0] ref_map(input logic [31:0] x);
        logic [65:0] p;
        logic [65:0] s;
        p = 66'(x) * (66'h1_0000_0000 - 66'(x));
        s = p >> 30;
        return (s >= 66'h1_0000_0000) ? 32'hFFFF_FFFF : s[31:0];
    endfunction

    function automatic int ref_clamp(input int v);
        return (v < 600) ? 600 : ((v > 800) ? 800 : v);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        seed_ld = 1'b0;
        run_en = 1'b0;
        intv_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_state = 32'h1000_0000;
        m_cnt = 0;
        m_intv = 700;
    endtask

    task automatic load_seed(input logic [31:0] s);
        seed_ld = 1'b1;
        seed_val = s;
        @(negedge clk);
        seed_ld = 1'b0;
        m_state = (s == 0) ? 32'h1000_0000 : s;
        m_cnt = 0;
    endtask

    task automatic write_intv(input int v);
        intv_wr = 1'b1;
        intv_val = 16'(v);
        @(negedge clk);
        intv_wr = 1'b0;
        m_intv = ref_clamp(v);
    endtask

    task automatic run_model(input int steps, input string req);
        run_en = 1'b1;
        for (int i = 0; i < steps; i++) begin
            bit rs;
            @(negedge clk);
            rs = (m_state == 0) || (m_state == 32'hFFFF_FFFF) || (m_cnt >= m_intv - 1);
            m_state = ref_map(rs ? {m_state[31:8], 8'hA5} : m_state);
            m_cnt = rs ? 0 : m_cnt + 1;
            check((rnd_out == m_state) && rnd_vld, req, rnd_out, m_state);
        end
        run_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        do_reset();
        // R1 reset state
        check(rnd_out == 32'h1000_0000, "R1 reset word", rnd_out, 32'h1000_0000);
        check(rnd_vld == 1'b0, "R1 reset valid", 32'(rnd_vld), 32'h0);

        // table walk: one iteration from each seed
        for (int k = 0; k < 7; k++) begin
            load_seed(VEC[k][63:32]);
            check(rnd_vld == 1'b0, "R4 no strobe on load", 32'(rnd_vld), 32'h0);
            run_en = 1'b1;
            @(negedge clk);
            run_en = 1'b0;
            check((rnd_out == VEC[k][31:0]) && rnd_vld, "R2 table step",
                  rnd_out, VEC[k][31:0]);
        end

        // R3 idle hold
        @(negedge clk);
        check(rnd_out == 32'h3C00_0000, "R3 hold word", rnd_out, 32'h3C00_0000);
        check(rnd_vld == 1'b0, "R3 valid low", 32'(rnd_vld), 32'h0);

        // R7 saturation leads to trapped state then injected step
        load_seed(32'h8000_0000);
        run_en = 1'b1;
        @(negedge clk);
        check(rnd_out == 32'hFFFF_FFFF, "R7 reach all-ones", rnd_out, 32'hFFFF_FFFF);
        @(negedge clk);
        run_en = 1'b0;
        check(rnd_out == 32'h0000_016B, "R7 forced reseed", rnd_out, 32'h0000_016B);

        // R4 load wins over enable
        run_en = 1'b1;
        seed_ld = 1'b1;
        seed_val = 32'h2000_0000;
        @(negedge clk);
        seed_ld = 1'b0;
        run_en = 1'b0;
        check((rnd_out == 32'h2000_0000) && !rnd_vld, "R4 load priority",
              rnd_out, 32'h2000_0000);

        // R6 periodic reseed at default interval, from fresh reset
        do_reset();
        run_model(1500, "R6 default interval orbit");

        // R5 clamp low and high
        write_intv(100);
        run_model(1300, "R5 clamped to 600");
        write_intv(1000);
        run_model(1700, "R5 clamped to 800");
        write_intv(650);
        run_model(1400, "R5 in-range 650");

        // R8 lower interval beneath current count
        load_seed(32'h1234_5678);
        write_intv(800);
        run_model(700, "R8 build count");
        write_intv(600);
        run_model(700, "R8 immediate reseed after lowering");

        // R9 word stays non-zero at end of the runs
        check(rnd_out != 32'h0, "R9 non-zero word", rnd_out, 32'h1);

        report();
    end
endmodule